// File: doc/BRIEF.md
# Indirect Control Register Bank Bridge

This block gives a host access to a bank of thirty-two 8-bit control registers through one 32-bit port register. The host never addresses the bank directly. Instead it packs a bank address, a data byte, a write strobe and a bank release bit into the port register. A write lands in the bank when the strobe bit changes from 0 to 1. The low byte of the port register always shows the bank register that the address field currently selects.

Writes are single-cycle. A write strobe on the host side updates the port register at the next rising clock edge, together with any bank write that the update causes. The read data is a combinational view of that state, so it reflects the new values right after the edge. All 256 bank bits are also driven out in parallel, so that downstream analog control logic can use them.

Top module: `ana_bank_bridge`

## Requirements
- R1: A synchronous active-high reset clears every port register field and every bank register to 0.
- R2: While the release bit (bit 28) is 0, every bank register reads as 0 and a strobe rising edge writes nothing.
- R3: With the release bit at 1, a 0-to-1 change of the strobe bit (bit 24) writes the data field (bits 15:8) into the bank register selected by the address field (bits 20:16).
- R4: While the strobe bit stays at 1, further host writes do not change the bank, even when they carry a new address or new data.
- R5: Bits 7:0 of the read data return the bank register selected by the current address field. Changing the address needs no strobe.
- R6: Bits 28, 24, 20:16 and 15:8 read back as last written. All other bits read as 0, whatever was written to them.
- R7: A host write that raises the strobe and also changes the address and data commits the newly written address and data.
- R8: Bank register i is driven on bank_flat[8*i+7:8*i].
- R9: Cycles without a host write change neither the port register nor the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_we | input | 1 | Host write strobe for the port register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Port register read value |
| bank_flat | output | 256 | All bank registers in parallel |

## Verification
Each host write takes effect at the rising edge that samples host_we. The port register fields, any bank commit, any bank clear, the read byte and bank_flat all become valid together, right after that edge, with no further latency. The bench drives each write on a falling edge and drops host_we at the next falling edge. It then samples host_rdata and bank_flat at that falling edge, one edge after the one that committed the write. Idle-cycle and held-strobe checks compare outputs across several such half-period-offset samples.

// File: rtl/anab_pkg.sv
package anab_pkg;
    localparam int HOST_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 8;
    localparam int NREG     = 1 << ADDR_W;
    localparam int FLAT_W   = NREG * DATA_W;
    localparam int REL_BIT  = 28;
    localparam int STB_BIT  = 24;
    localparam int ADDR_LSB = 16;
    localparam int WDAT_LSB = 8;

    typedef struct packed {
        logic              rel;
        logic              stb;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdat;
    } port_t;

    typedef struct packed {
        logic              en;
        logic              clr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bank_cmd_t;

    function automatic port_t port_decode(input logic [HOST_W-1:0] w);
        port_t p;
        p.rel  = w[REL_BIT];
        p.stb  = w[STB_BIT];
        p.addr = w[ADDR_LSB +: ADDR_W];
        p.wdat = w[WDAT_LSB +: DATA_W];
        return p;
    endfunction

    function automatic logic [HOST_W-1:0] port_encode(input port_t p,
                                                      input logic [DATA_W-1:0] rd);
        logic [HOST_W-1:0] r;
        r = '0;
        r[REL_BIT]              = p.rel;
        r[STB_BIT]              = p.stb;
        r[ADDR_LSB +: ADDR_W]   = p.addr;
        r[WDAT_LSB +: DATA_W]   = p.wdat;
        r[DATA_W-1:0]           = rd;
        return r;
    endfunction
endpackage

// File: rtl/anab_port_ctl.sv
module anab_port_ctl
    import anab_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [HOST_W-1:0] host_wdata,
    output port_t             port_q,
    output bank_cmd_t         cmd
);
    port_t nxt;

    always_comb begin
        nxt      = host_we ? port_decode(host_wdata) : port_q;
        cmd.en   = nxt.rel && nxt.stb && !port_q.stb;
        cmd.clr  = !nxt.rel;
        cmd.addr = nxt.addr;
        cmd.data = nxt.wdat;
    end

    always_ff @(posedge clk) begin
        if (rst) port_q <= '0;
        else     port_q <= nxt;
    end
endmodule

// File: rtl/anab_reg_bank.sv
module anab_reg_bank
    import anab_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  bank_cmd_t      cmd,
    output logic [N*W-1:0] bank_flat
);
    for (genvar i = 0; i < N; i++) begin : g_reg
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst || cmd.clr)
                q <= '0;
            else if (cmd.en && (cmd.addr == ADDR_W'(i)))
                q <= cmd.data;
        end
        assign bank_flat[i*W +: W] = q;
    end
endmodule

// File: rtl/anab_rd_mux.sv
module anab_rd_mux
    import anab_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = DATA_W
) (
    input  logic [N*W-1:0]    bank_flat,
    input  logic [ADDR_W-1:0] addr,
    output logic [W-1:0]      rd
);
    assign rd = bank_flat[addr*W +: W];
endmodule

// File: rtl/ana_bank_bridge.sv
module ana_bank_bridge
    import anab_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    output logic [FLAT_W-1:0] bank_flat
);
    port_t             port_q;
    bank_cmd_t         cmd;
    logic [DATA_W-1:0] rd_byte;

    anab_port_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .port_q     (port_q),
        .cmd        (cmd)
    );

    anab_reg_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .bank_flat (bank_flat)
    );

    anab_rd_mux u_mux (
        .bank_flat (bank_flat),
        .addr      (port_q.addr),
        .rd        (rd_byte)
    );

    assign host_rdata = port_encode(port_q, rd_byte);
endmodule

// File: rtl/anab_checker.sv
module anab_checker
    import anab_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              host_we,
    input logic [HOST_W-1:0] host_wdata,
    input logic [HOST_W-1:0] host_rdata,
    input logic [FLAT_W-1:0] bank_flat
);
    localparam logic [HOST_W-1:0] LIVE = (HOST_W'(1) << REL_BIT) | (HOST_W'(1) << STB_BIT)
        | (HOST_W'((1 << ADDR_W) - 1) << ADDR_LSB) | (HOST_W'((1 << DATA_W) - 1) << WDAT_LSB)
        | HOST_W'((1 << DATA_W) - 1);

    assert_held_clear_R2: assert property (@(posedge clk) disable iff (rst)
        !host_rdata[REL_BIT] |-> (bank_flat == '0));

    assert_unused_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (host_rdata & ~LIVE) == '0);

    assert_readback_R6: assert property (@(posedge clk) disable iff (rst)
        host_we |=> ((host_rdata & LIVE & ~HOST_W'((1 << DATA_W) - 1))
                     == ($past(host_wdata) & LIVE & ~HOST_W'((1 << DATA_W) - 1))));

    assert_commit_R3: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_wdata[REL_BIT] && host_wdata[STB_BIT] && !host_rdata[STB_BIT])
        |=> (host_rdata[DATA_W-1:0] == $past(host_wdata[WDAT_LSB +: DATA_W])));

    assert_held_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_wdata[STB_BIT] && host_rdata[STB_BIT]
         && host_wdata[REL_BIT] && host_rdata[REL_BIT]) |=> $stable(bank_flat));

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !host_we |=> ($stable(bank_flat) && $stable(host_rdata)));
endmodule

bind ana_bank_bridge anab_checker u_chk (.*);

// File: tb/tb_ana_bank_bridge.sv
module tb_ana_bank_bridge;
    import anab_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_we = 1'b0;
    logic [HOST_W-1:0] host_wdata = '0;
    logic [HOST_W-1:0] host_rdata;
    logic [FLAT_W-1:0] bank_flat;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ana_bank_bridge dut (.*);

    // {write value, expected read value after the write}
    localparam int NV = 12;
    localparam logic [63:0] VEC [NV] = '{
        {32'h1000_0000, 32'h1000_0000},   // R6 release only
        {32'h1003_A500, 32'h1003_A500},   // R5 addr 3 still 0
        {32'h1103_A500, 32'h1103_A5A5},   // R3 strobe edge commits
        {32'h1003_A500, 32'h1003_A5A5},   // R6 strobe cleared
        {32'h111F_3C00, 32'h111F_3C3C},   // R7 new addr+data with edge
        {32'h111F_7700, 32'h111F_773C},   // R4 strobe held high
        {32'h1003_0000, 32'h1003_00A5},   // R5 address change, no strobe
        {32'hFFFF_FF00, 32'h111F_FFFF},   // R6 junk bits dropped
        {32'h001F_0000, 32'h001F_0000},   // R2 release low clears
        {32'h011F_5500, 32'h011F_5500},   // R2 edge ignored
        {32'h101F_0000, 32'h101F_0000},   // R2 nothing written
        {32'h1000_0000, 32'h1000_0000}    // R2 reg 0 also clear
    };
    string tags [NV] = '{"R6", "R5", "R3", "R6", "R7", "R4", "R5", "R6", "R2", "R2", "R2", "R2"};

    task automatic check(input string req, input logic [FLAT_W-1:0] act,
                         input logic [FLAT_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [HOST_W-1:0] v);
        @(negedge clk);
        host_we    = 1'b1;
        host_wdata = v;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [FLAT_W-1:0] snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset rdata", FLAT_W'(host_rdata), '0);
        check("R1 reset bank", bank_flat, '0);

        for (int i = 0; i < NV; i++) begin
            host_write(VEC[i][63:32]);
            check(tags[i], FLAT_W'(host_rdata), FLAT_W'(VEC[i][31:0]));
        end

        // R8: parallel placement of bank registers
        host_write(32'h1100_1100);
        host_write(32'h1000_0000);
        host_write(32'h111F_2200);
        host_write(32'h1000_0000);
        check("R8 reg0 lane", FLAT_W'(bank_flat[7:0]), FLAT_W'(8'h11));
        check("R8 reg31 lane", FLAT_W'(bank_flat[255:248]), FLAT_W'(8'h22));
        check("R8 other lanes", bank_flat & ~{8'hFF, 240'h0, 8'hFF}, '0);

        // R9: idle cycles change nothing
        snap = bank_flat;
        repeat (5) @(negedge clk);
        check("R9 bank idle", bank_flat, snap);
        check("R9 rdata idle", FLAT_W'(host_rdata), FLAT_W'(32'h1000_0011));

        // R3/R2: release and strobe raised in the same write commits
        host_write(32'h0000_0000);
        host_write(32'h1105_6600);
        check("R3 release+edge together", FLAT_W'(host_rdata), FLAT_W'(32'h1105_6666));

        // R1: reset mid run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid reset rdata", FLAT_W'(host_rdata), '0);
        check("R1 mid reset bank", bank_flat, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule